// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is the serial front end of a byte-addressed EEPROM that sits on an SPI bus as a slave, in clock mode 0 or mode 3. A fast system clock oversamples chip select, serial clock, serial data in and a hold input. The block recognises the rising and falling serial clock edges inside its own clock domain. It decodes an 8-bit instruction and captures a 16-bit address. It then streams array bytes or a status byte out on a serial output that has its own output enable, or it gathers write data into a page latch.

A page write lands in a latch one page wide. The write offset wraps inside the page. When chip select is released on a byte boundary, the latch contents are committed to an on-chip byte array in a single cycle. The status register contents, the write-enable policy and the busy timer all live in a companion controller. This block hands that controller one-cycle pulses for the enable, disable and status-write instructions. It receives back a live status byte, a busy flag and a write-permission flag.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Bits on `si` are taken most significant first on rising serial clock edges. Instruction 0x03 followed by a 16-bit address returns the byte at that address on `so`, most significant bit first, with `so` updated after falling edges.
- R2: A read keeps streaming while clocks continue, and the address advances by one per byte. Address bits above log2(DEPTH) are ignored, so the stream wraps from DEPTH-1 to 0.
- R3: Instruction 0x02 followed by a 16-bit address stores each following byte at the next slot of the same PAGE-byte page. The page starts at the address with its low log2(PAGE) bits cleared. Slots past the last one wrap to slot 0 of that page and overwrite it.
- R4: A write is committed only when chip select rises with no partial byte pending and at least one data byte received, while `wr_allowed` is 1 and `busy` is 0. `commit_req` is then a one-cycle pulse carrying the page base, the starting slot and the byte count, which saturates at PAGE.
- R5: A chip select rise in the middle of a data byte discards the whole write, and the array keeps its old contents.
- R6: `so_oe` is 0 while deselected, after reset, and in every phase that is not driving read or status data.
- R7: While `busy` is 1, array reads (no output enable) and array writes (no commit) are ignored. Instruction 0x05 still returns `status_in`, repeated for every further byte.
- R8: Instruction 0x06 pulses `wren_pulse` and instruction 0x04 pulses `wrdi_pulse`, each only when chip select rises after exactly 8 bits. Instruction 0x01 plus one byte pulses `wrsr_pulse`, with that byte on `wrsr_data`, only when chip select rises after exactly 16 bits.
- R9: With `hold_n` low while the serial clock is low, `so_oe` drops and serial clock edges are ignored. Releasing the hold resumes the transfer at the bit where it stopped.
- R10: A change on `hold_n` made while the serial clock is high takes effect only once the clock has gone low. The falling edge that ends that high phase is still processed.
- R11: The serial clock may idle low (mode 0) or high (mode 3) between transfers, and both give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| busy | input | 1 | Controller reports an internal write cycle in progress |
| wr_allowed | input | 1 | Controller permits the pending page write |
| status_in | input | 8 | Status byte returned for instruction 0x05 |
| wren_pulse | output | 1 | Write-enable instruction completed |
| wrdi_pulse | output | 1 | Write-disable instruction completed |
| wrsr_pulse | output | 1 | Status-write instruction completed |
| wrsr_data | output | 8 | Byte accompanying `wrsr_pulse` |
| commit_req | output | 1 | Page write committed to the array this cycle |
| commit_base | output | 16 | Base address of the page being written |
| commit_off | output | log2(PAGE) | Starting slot of the write within the page |
| commit_cnt | output | log2(PAGE)+1 | Number of bytes received, saturated at PAGE |

## Verification
A falling serial clock edge can arrive in the same cycle that a deferred hold request takes effect: the fall shifts the next read bit onto `so` while the hold freezes everything after it. The bench provokes this by pulling `hold_n` low during a high clock phase in the middle of a read byte. It then checks that the output stays enabled until the clock falls and is disabled afterwards. Extra clocks given during the hold must be ignored, and once the hold is released the reassembled byte must equal the stored one, which shows that the coinciding fall advanced exactly one bit. Constrained random page writes, with random start slots, lengths and clock modes, are then read back page by page against a model of the wrap rule.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } eep_op_e;

  typedef enum logic [2:0] {
    S_OP, S_AHI, S_ALO, S_STREAM, S_WDATA, S_WSR, S_TAIL, S_IGN
  } eep_state_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eep_front.sv
module eep_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_bit,
  output logic sck_lvl,
  output logic held
);
  logic [3:0] s;
  logic       cs_q, sck_q;

  eep_sync #(.W(4), .RST(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si, hold_n}), .q(s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      cs_q  <= s[3];
      sck_q <= s[2];
      if (s[3])       held <= 1'b0;
      else if (!s[2]) held <= !s[0];  // hold changes only while clock is low
    end
  end

  assign cs_act   = !s[3];
  assign cs_rise  = s[3] && !cs_q;
  assign sck_rise = cs_act && !held && s[2] && !sck_q;
  assign sck_fall = cs_act && !held && !s[2] && sck_q;
  assign si_bit   = s[1];
  assign sck_lvl  = s[2];
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
  parameter int DEPTH = 4096,
  parameter int PAGE  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [7:0]    wr_byte,
  input  logic          commit,
  input  logic [AW-1:0] commit_base,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0]      mem [DEPTH];
  logic [7:0]      lat [PAGE];
  logic [PAGE-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (wr_en) vld[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) lat[wr_slot] <= wr_byte;
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (vld[PW'(i)]) mem[commit_base + AW'(i)] <= lat[PW'(i)];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import eep_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int PAGE  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sck,
  input  logic                     si,
  input  logic                     hold_n,
  output logic                     so,
  output logic                     so_oe,
  input  logic                     busy,
  input  logic                     wr_allowed,
  input  logic [7:0]               status_in,
  output logic                     wren_pulse,
  output logic                     wrdi_pulse,
  output logic                     wrsr_pulse,
  output logic [7:0]               wrsr_data,
  output logic                     commit_req,
  output logic [15:0]              commit_base,
  output logic [$clog2(PAGE)-1:0]  commit_off,
  output logic [$clog2(PAGE):0]    commit_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam logic [PW:0] PAGE_CNT = (PW+1)'(PAGE);

  function automatic logic [15:0] page_base(input logic [15:0] a);
    return a & ~16'(PAGE - 1);
  endfunction
  function automatic logic [AW-1:0] arr_idx(input logic [15:0] a);
    return a[AW-1:0];
  endfunction

  logic cs_act, cs_rise, sck_rise, sck_fall, si_bit, sck_lvl, held;
  eep_state_e  st;
  logic [2:0]  bit_cnt;
  logic [6:0]  sh;
  logic [7:0]  op_q, out_sr, rd_data;
  logic [15:0] addr_q;
  logic [PW-1:0] slot_q, start_q;
  logic [PW:0] nbytes_q;
  logic        out_ok;

  wire [7:0] byte_in   = {sh, si_bit};
  wire       byte_done = sck_rise && (bit_cnt == 3'd7);
  wire       lat_clr   = byte_done && (st == S_ALO);
  wire       lat_wr    = byte_done && (st == S_WDATA);

  eep_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_bit), .sck_lvl(sck_lvl), .held(held)
  );

  eep_pagebuf #(.DEPTH(DEPTH), .PAGE(PAGE)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(lat_clr), .wr_en(lat_wr), .wr_slot(slot_q),
    .wr_byte(byte_in), .commit(commit_req), .commit_base(arr_idx(commit_base)),
    .rd_addr(arr_idx(addr_q)), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; bit_cnt <= '0; sh <= '0; op_q <= '0; out_sr <= '0; addr_q <= '0;
      slot_q <= '0; start_q <= '0; nbytes_q <= '0; out_ok <= 1'b0;
      wren_pulse <= 1'b0; wrdi_pulse <= 1'b0; wrsr_pulse <= 1'b0; wrsr_data <= '0;
      commit_req <= 1'b0;
    end else begin
      wren_pulse <= 1'b0; wrdi_pulse <= 1'b0; wrsr_pulse <= 1'b0; commit_req <= 1'b0;
      if (cs_rise && bit_cnt == 3'd0) begin
        if (st == S_TAIL) begin
          wren_pulse <= (op_q == OP_WREN);
          wrdi_pulse <= (op_q == OP_WRDI);
          wrsr_pulse <= (op_q == OP_WRSR);
        end
        if (st == S_WDATA && nbytes_q != '0 && wr_allowed && !busy) commit_req <= 1'b1;
      end
      if (!cs_act) begin
        st <= S_OP; bit_cnt <= '0; out_ok <= 1'b0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        sh      <= {sh[5:0], si_bit};
        if (st == S_AHI || st == S_ALO) addr_q <= {addr_q[14:0], si_bit};
        if (st == S_TAIL) st <= S_IGN;  // any clock past the command voids it
        else if (byte_done) begin
          case (st)
            S_OP: begin
              op_q <= byte_in;
              case (byte_in)
                OP_READ, OP_WRITE: st <= S_AHI;
                OP_RDSR:           st <= S_STREAM;
                OP_WRSR:           st <= S_WSR;
                OP_WREN, OP_WRDI:  st <= S_TAIL;
                default:           st <= S_IGN;
              endcase
            end
            S_AHI: st <= S_ALO;
            S_ALO: begin
              if (busy)                 st <= S_IGN;
              else if (op_q == OP_READ) st <= S_STREAM;
              else begin
                st       <= S_WDATA;
                nbytes_q <= '0;
                slot_q   <= {addr_q[PW-2:0], si_bit};
                start_q  <= {addr_q[PW-2:0], si_bit};
              end
            end
            S_WDATA: begin
              slot_q <= slot_q + 1'b1;  // wraps inside the page
              if (nbytes_q != PAGE_CNT) nbytes_q <= nbytes_q + 1'b1;
            end
            S_WSR: begin
              wrsr_data <= byte_in;
              st        <= S_TAIL;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && st == S_STREAM) begin
        if (bit_cnt == 3'd0) begin
          out_ok <= 1'b1;
          if (op_q == OP_RDSR) out_sr <= status_in;
          else begin
            out_sr <= rd_data;
            addr_q <= addr_q + 16'd1;
          end
        end else begin
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign so          = out_sr[7];
  assign so_oe       = cs_act && !held && (st == S_STREAM) && out_ok;
  assign commit_base = page_base(addr_q);
  assign commit_off  = start_q;
  assign commit_cnt  = nbytes_q;
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int PAGE = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_n,
  input logic                    so_oe,
  input logic                    busy,
  input logic                    wr_allowed,
  input logic                    commit_req,
  input logic [$clog2(PAGE):0]   commit_cnt,
  input logic                    wren_pulse,
  input logic                    wrdi_pulse,
  input logic                    wrsr_pulse,
  input logic                    held,
  input logic                    sck_lvl,
  input logic [2:0]              bit_cnt
);
  p_oe_off_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  p_commit_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req);

  p_commit_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> ($past(wr_allowed) && !$past(busy) &&
                    commit_cnt != '0 && commit_cnt <= ($clog2(PAGE)+1)'(PAGE)));

  p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_pulse, wrdi_pulse, wrsr_pulse, commit_req}));

  p_hold_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(bit_cnt));

  p_hold_enters_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_lvl));
endmodule

bind spi_eeprom_slave eep_chk #(.PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .busy(busy),
  .wr_allowed(wr_allowed), .commit_req(commit_req), .commit_cnt(commit_cnt),
  .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .wrsr_pulse(wrsr_pulse),
  .held(held), .sck_lvl(sck_lvl), .bit_cnt(bit_cnt)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
  localparam int DEPTH = 4096;
  localparam int PAGE  = 32;
  localparam int PW    = $clog2(PAGE);
  localparam int H     = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic busy = 1'b0, wr_allowed = 1'b1;
  logic [7:0] status_in = 8'h00;
  logic so, so_oe, wren_pulse, wrdi_pulse, wrsr_pulse, commit_req;
  logic [7:0] wrsr_data;
  logic [15:0] commit_base;
  logic [PW-1:0] commit_off;
  logic [PW:0] commit_cnt;

  always #5 clk = ~clk;

  spi_eeprom_slave #(.DEPTH(DEPTH), .PAGE(PAGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .wr_allowed(wr_allowed), .status_in(status_in),
    .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .wrsr_pulse(wrsr_pulse),
    .wrsr_data(wrsr_data), .commit_req(commit_req), .commit_base(commit_base),
    .commit_off(commit_off), .commit_cnt(commit_cnt)
  );

  int checks = 0, errors = 0;
  int n_commit = 0, n_wren = 0, n_wrdi = 0, n_wrsr = 0;
  logic [15:0] c_base;
  logic [PW-1:0] c_off;
  logic [PW:0] c_cnt;
  logic [7:0] c_sr;
  logic [7:0] shadow [DEPTH];
  bit known [DEPTH];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];
  bit roe;
  bit idle_lvl = 1'b0;

  always @(negedge clk) begin
    if (commit_req) begin n_commit++; c_base = commit_base; c_off = commit_off; c_cnt = commit_cnt; end
    if (wren_pulse) n_wren++;
    if (wrdi_pulse) n_wrdi++;
    if (wrsr_pulse) begin n_wrsr++; c_sr = wrsr_data; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    idle_lvl = m3; sck = m3; wait_clk(H);
    cs_n = 1'b0; wait_clk(H);
  endtask

  task automatic desel();
    sck = idle_lvl; wait_clk(H);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic xbit(input bit b, output bit r, output bit oe);
    sck = 1'b0; si = b; wait_clk(H);
    r = so; oe = so_oe;
    sck = 1'b1; wait_clk(H);
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r, output bit oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit x, o;
      xbit(t[i], x, o);
      r[i] = x;
      oe_all &= o;
    end
  endtask

  task automatic send(input logic [7:0] t);
    logic [7:0] r; bit o;
    xbyte(t, r, o);
  endtask

  function automatic int wr_slot_addr(input logic [15:0] a, input int i);
    int off = int'(a) % PAGE;
    int base = int'(a) - off;
    return (base + (off + i) % PAGE) % DEPTH;
  endfunction

  function automatic void model_write(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      shadow[wr_slot_addr(a, i)] = wbuf[i];
      known[wr_slot_addr(a, i)]  = 1'b1;
    end
  endfunction

  task automatic do_write(input bit m3, input logic [15:0] a, input int n);
    sel(m3);
    send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) send(wbuf[i]);
    desel();
  endtask

  task automatic do_read(input bit m3, input logic [15:0] a, input int n);
    logic [7:0] r; bit o;
    sel(m3);
    send(8'h03); send(a[15:8]); send(a[7:0]);
    roe = 1'b1;
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r, o);
      rbuf[i] = r; roe &= o;
    end
    desel();
  endtask

  function automatic int rd_idx(input logic [15:0] a, input int i);
    return (int'(a) % DEPTH + i) % DEPTH;
  endfunction

  task automatic run_tests();
    int nc, bad, exp_cnt;
    logic [7:0] r, r2;
    bit o, o2, x, xo;
    logic [15:0] a;

    // Reset state
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    chk(so_oe == 1'b0, "R6 so_oe after reset", so_oe, 0);
    chk(commit_req == 1'b0, "R4 no commit after reset", commit_req, 0);

    // Basic write then read in mode 3
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    nc = n_commit;
    do_write(1'b0, 16'h0100, 4); model_write(16'h0100, 4);
    chk(n_commit == nc + 1, "R4 commit pulse count", n_commit, nc + 1);
    chk(c_base == 16'h0100 && c_off == 0 && c_cnt == 4, "R4 commit fields",
        {c_base, 3'b0, c_off, 2'b0, c_cnt}, {16'h0100, 16'h0004});
    do_read(1'b1, 16'h0100, 4);
    chk(roe, "R6 so_oe during read data", roe, 1);
    for (int i = 0; i < 4; i++) chk(rbuf[i] == shadow[256 + i], "R1 R11 read byte", rbuf[i], shadow[256 + i]);

    // Page wrap write: slot 30 of page 0x0200, five bytes
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(1'b1, 16'h021E, 5); model_write(16'h021E, 5);
    chk(c_base == 16'h0200 && c_off == 30 && c_cnt == 5, "R3 wrap commit fields",
        {c_base, 3'b0, c_off, 2'b0, c_cnt}, {16'h0200, 16'h1E05});
    do_read(1'b0, 16'h0200, PAGE);
    bad = 0;
    for (int i = 0; i < PAGE; i++) if (known[rd_idx(16'h0200, i)] && rbuf[i] !== shadow[rd_idx(16'h0200, i)]) bad++;
    chk(bad == 0 && rbuf[0] == 8'hA2 && rbuf[31] == 8'hA1, "R3 wrap inside page", rbuf[0], 8'hA2);

    // Read wraps past the top of the array, upper address bits ignored
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; do_write(1'b0, 16'h0FFE, 2); model_write(16'h0FFE, 2);
    wbuf[0] = 8'h7C; wbuf[1] = 8'h8D; do_write(1'b0, 16'h0000, 2); model_write(16'h0000, 2);
    do_read(1'b0, 16'hFFFE, 4);
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'h6B, "R2 top bytes via high address", {rbuf[0], rbuf[1]}, 16'h5A6B);
    chk(rbuf[2] == 8'h7C && rbuf[3] == 8'h8D, "R2 wrap to zero", {rbuf[2], rbuf[3]}, 16'h7C8D);

    // Aborted write in the middle of a byte
    wbuf[0] = 8'hAA; do_write(1'b0, 16'h0300, 1); model_write(16'h0300, 1);
    nc = n_commit;
    sel(1'b0); send(8'h02); send(8'h03); send(8'h00); send(8'h55);
    for (int i = 0; i < 3; i++) xbit(1'b1, x, xo);
    desel();
    chk(n_commit == nc, "R5 no commit on partial byte", n_commit, nc);
    do_read(1'b0, 16'h0300, 1);
    chk(rbuf[0] == 8'hAA, "R5 array unchanged", rbuf[0], 8'hAA);

    // Address only, no data byte
    sel(1'b0); send(8'h02); send(8'h03); send(8'h00); desel();
    chk(n_commit == nc, "R4 no commit without data", n_commit, nc);

    // Controller refuses the write
    wr_allowed = 1'b0; wbuf[0] = 8'h77;
    do_write(1'b1, 16'h0300, 1);
    wr_allowed = 1'b1;
    chk(n_commit == nc, "R4 no commit when refused", n_commit, nc);
    do_read(1'b0, 16'h0300, 1);
    chk(rbuf[0] == 8'hAA, "R4 refused write leaves array", rbuf[0], 8'hAA);

    // Busy: status still served, array access ignored
    busy = 1'b1; status_in = 8'hA5;
    sel(1'b0); send(8'h05); xbyte(8'h00, r, o); xbyte(8'h00, r2, o2); desel();
    chk(r == 8'hA5 && r2 == 8'hA5 && o && o2, "R7 status during busy", {r, r2}, 16'hA5A5);
    do_read(1'b0, 16'h0100, 1);
    chk(roe == 1'b0, "R7 read ignored while busy", roe, 0);
    wbuf[0] = 8'h99; do_write(1'b0, 16'h0100, 1);
    chk(n_commit == nc, "R7 write ignored while busy", n_commit, nc);
    busy = 1'b0;
    do_read(1'b0, 16'h0100, 1);
    chk(rbuf[0] == 8'h11, "R7 array intact after busy", rbuf[0], 8'h11);

    // Enable, disable and status-write instructions
    sel(1'b0); send(8'h06); desel();
    chk(n_wren == 1, "R8 enable pulse", n_wren, 1);
    sel(1'b1); send(8'h04); desel();
    chk(n_wrdi == 1, "R8 disable pulse", n_wrdi, 1);
    sel(1'b0); send(8'h06); for (int i = 0; i < 3; i++) xbit(1'b0, x, xo); desel();
    chk(n_wren == 1, "R8 enable voided by extra clocks", n_wren, 1);
    sel(1'b0); send(8'h01); send(8'h8C); desel();
    chk(n_wrsr == 1 && c_sr == 8'h8C, "R8 status write pulse and data", c_sr, 8'h8C);
    sel(1'b0); send(8'h01); desel();
    chk(n_wrsr == 1, "R8 status write needs data byte", n_wrsr, 1);

    // Hold in the middle of a read byte, requested while the clock is high
    sel(1'b0); send(8'h03); send(8'h01); send(8'h00);
    for (int i = 7; i >= 5; i--) begin xbit(1'b0, x, xo); r[i] = x; end
    hold_n = 1'b0; wait_clk(H);
    chk(so_oe == 1'b1, "R10 hold deferred while clock high", so_oe, 1);
    sck = 1'b0; wait_clk(H);
    chk(so_oe == 1'b0, "R9 output released during hold", so_oe, 0);
    for (int k = 0; k < 2; k++) begin sck = 1'b1; si = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H); end
    hold_n = 1'b1; wait_clk(H);
    chk(so_oe == 1'b1, "R9 output back after hold", so_oe, 1);
    for (int i = 4; i >= 0; i--) begin xbit(1'b0, x, xo); r[i] = x; end
    desel();
    chk(r == 8'h11, "R9 R10 byte resumes intact", r, 8'h11);

    // Constrained random page writes
    for (int it = 0; it < 12; it++) begin
      int n;
      bit m3;
      a  = 16'($urandom);
      n  = 1 + int'($urandom % 36);
      m3 = 1'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      nc = n_commit;
      do_write(m3, a, n); model_write(a, n);
      exp_cnt = (n > PAGE) ? PAGE : n;
      chk(n_commit == nc + 1 && c_off == PW'(a) && int'(c_cnt) == exp_cnt,
          "R4 random commit fields", int'(c_cnt), exp_cnt);
      do_read(!m3, a & ~16'(PAGE - 1), PAGE);
      bad = 0;
      for (int i = 0; i < PAGE; i++) begin
        int ix = rd_idx(a & ~16'(PAGE - 1), i);
        if (known[ix] && rbuf[i] !== shadow[ix]) bad++;
      end
      chk(bad == 0, "R3 R11 random page readback", bad, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule